// File: doc/BRIEF.md
# Load-Reserved Store-Conditional Monitor

This block sits between several processor ports and one shared memory bus. It holds a small word memory and watches every write to it, so that processors can build atomic read-modify-write sequences out of a reserving load and a conditional store. A reserving load returns a word and notes, for the requesting port, which cache block it came from. A conditional store from that port succeeds only if nothing else has written to that block since the reserving load. It reports success or failure and writes memory only on success.

Each cycle at most one port operation reaches the bus. The lowest-numbered requesting port wins. A port that loses keeps its request raised until it is granted. A separate write input stands for another bus agent, such as a DMA engine. When that input is active it owns the bus for the cycle and blocks every port.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is pending, no port holds a reservation, and every memory word reads as zero.
- R2: At most one port is granted per cycle. The grant goes to the lowest-indexed port with `req_vld` high. No port is granted while `ext_wr_en` is high. A port that is not granted keeps waiting.
- R3: Each grant is answered in the following cycle. `rsp_vld` is raised for the granted port, and `rsp_data` carries the word as it was before the operation. Operation codes on `req_op` are 0 = load, 1 = store, 2 = reserving load, 3 = conditional store.
- R4: A reserving load returns the addressed word, records a reservation for its port on that block, and raises `bus_rd` but never `bus_wr`.
- R5: A conditional store succeeds when its port holds a valid reservation on the same block. Blocks compare byte-address bits 9..4 with the default 16-byte blocks. On success it writes memory, raises `bus_wr` in its grant cycle, and returns `rsp_sc_ok` = 1.
- R6: A failed conditional store leaves memory unchanged, keeps `bus_wr` low, and returns `rsp_sc_ok` = 0.
- R7: A store or a successful conditional store by one port cancels every other port's reservation on that block. A port's own plain store does not cancel its own reservation.
- R8: A write on the external agent input cancels all reservations on the written block.
- R9: A conditional store always clears its own port's reservation, whether it succeeds or fails. A new reserving load replaces the port's older reservation.
- R10: A write to a different block leaves a reservation intact. A write to another word of the same block cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NPORTS | Request valid, one bit per port, held until granted |
| req_op | input | 2*NPORTS | Operation code per port |
| req_addr | input | AW*NPORTS | Byte address per port, word aligned |
| req_wdata | input | DW*NPORTS | Store data per port |
| gnt | output | NPORTS | Grant this cycle, at most one bit |
| ext_wr_en | input | 1 | Write from another bus agent |
| ext_wr_addr | input | AW | External write byte address |
| ext_wr_data | input | DW | External write data |
| bus_rd | output | 1 | Bus read this cycle |
| bus_wr | output | 1 | Bus write, or invalidation, this cycle |
| bus_addr | output | AW | Address on the bus this cycle |
| rsp_vld | output | NPORTS | Response valid for a port |
| rsp_data | output | DW | Word read by the answered operation |
| rsp_sc_ok | output | 1 | Conditional store success flag |

## Verification
`gnt`, `bus_rd`, `bus_wr` and `bus_addr` are combinational. They are due in the same cycle the request is presented. `rsp_vld`, `rsp_data` and `rsp_sc_ok` are due one clock edge later. A reservation change shows up only in the next conditional store that port makes. The bench drives inputs on the falling edge. It reads the bus outputs 1 ns later, before the rising edge. It reads the responses at the following falling edge, so every sample lands exactly one register stage after its cause.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NPORTS    = 4,
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int BLK_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_vld,
  input  logic [2*NPORTS-1:0]  req_op,
  input  logic [AW*NPORTS-1:0] req_addr,
  input  logic [DW*NPORTS-1:0] req_wdata,
  output logic [NPORTS-1:0]    gnt,
  input  logic                 ext_wr_en,
  input  logic [AW-1:0]        ext_wr_addr,
  input  logic [DW-1:0]        ext_wr_data,
  output logic                 bus_rd,
  output logic                 bus_wr,
  output logic [AW-1:0]        bus_addr,
  output logic [NPORTS-1:0]    rsp_vld,
  output logic [DW-1:0]        rsp_data,
  output logic                 rsp_sc_ok
);
  localparam int WLSB  = 2;
  localparam int BLSB  = $clog2(BLK_BYTES);
  localparam int DEPTH = 1 << (AW - WLSB);
  localparam int BW    = AW - BLSB;
  localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0]   mem [DEPTH];
  logic [NPORTS-1:0] resv_vld;
  logic [BW-1:0]   resv_blk [NPORTS];

  logic [PW-1:0]   sel;
  logic            any;
  logic [1:0]      op;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wdata;
  logic [BW-1:0]   blk, wr_blk;
  logic            sc_pass, port_wr;

  always_comb begin
    gnt = '0;
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      if (!any && req_vld[i] && !ext_wr_en) begin
        gnt[i] = 1'b1;
        sel    = PW'(i);
        any    = 1'b1;
      end
  end

  assign op      = req_op[sel*2 +: 2];
  assign addr    = req_addr[sel*AW +: AW];
  assign wdata   = req_wdata[sel*DW +: DW];
  assign blk     = addr[AW-1:BLSB];
  assign sc_pass = any && op == OP_SC && resv_vld[sel] && resv_blk[sel] == blk;
  assign port_wr = any && (op == OP_ST || sc_pass);
  assign bus_wr  = ext_wr_en | port_wr;
  assign bus_rd  = any && (op == OP_LD || op == OP_LL);
  assign bus_addr = ext_wr_en ? ext_wr_addr : addr;
  assign wr_blk  = bus_addr[AW-1:BLSB];

  for (genvar i = 0; i < NPORTS; i++) begin : g_resv
    logic mine;
    assign mine = any && sel == PW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resv_vld[i] <= 1'b0;
        resv_blk[i] <= '0;
      end else if (mine && op == OP_LL) begin
        resv_vld[i] <= 1'b1;
        resv_blk[i] <= blk;
      end else if (mine && op == OP_SC) begin
        resv_vld[i] <= 1'b0;
      end else if (bus_wr && resv_blk[i] == wr_blk && !(port_wr && mine)) begin
        resv_vld[i] <= 1'b0;
      end
    end

    // R8
    ext_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr_en && resv_vld[i] && resv_blk[i] == ext_wr_addr[AW-1:BLSB]) |=> !resv_vld[i]);

    if (i > 0) begin : g_pri
      // R2
      fixed_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[i] |-> (req_vld[i-1:0] == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (bus_wr) begin
      mem[bus_addr[AW-1:WLSB]] <= ext_wr_en ? ext_wr_data : wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= '0;
      rsp_data  <= '0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_vld   <= gnt;
      rsp_data  <= mem[addr[AW-1:WLSB]];
      rsp_sc_ok <= sc_pass;
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R2
  ext_block_chk: assert property (@(posedge clk) disable iff (!rst_n) ext_wr_en |-> gnt == '0);
  // R3
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |=> $countones(rsp_vld) == 1);
  // R4
  ll_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any && op == OP_LL) |-> (bus_rd && !bus_wr));
  // R6
  sc_fail_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any && op == OP_SC && !ext_wr_en) |=> (rsp_sc_ok == $past(bus_wr)));
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int N = 4, AW = 10, DW = 32;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_vld = '0;
  logic [2*N-1:0] req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0] gnt, rsp_vld;
  logic ext_wr_en = 1'b0;
  logic [AW-1:0] ext_wr_addr = '0, bus_addr;
  logic [DW-1:0] ext_wr_data = '0, rsp_data;
  logic bus_rd, bus_wr, rsp_sc_ok;
  int total = 0, failed = 0;

  always #2 clk = ~clk;

  llsc_monitor #(.NPORTS(N), .AW(AW), .DW(DW), .BLK_BYTES(16)) u0 (
    .clk, .rst_n, .req_vld, .req_op, .req_addr, .req_wdata, .gnt,
    .ext_wr_en, .ext_wr_addr, .ext_wr_data, .bus_rd, .bus_wr, .bus_addr,
    .rsp_vld, .rsp_data, .rsp_sc_ok);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW-1:0] r_data;
  logic r_ok, r_rd, r_wr;

  task automatic set_req(int p, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    req_vld[p] = 1'b1;
    req_op[p*2 +: 2] = op;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
  endtask

  task automatic do_op(int p, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    set_req(p, op, a, d);
    #1;
    r_rd = bus_rd;
    r_wr = bus_wr;
    @(negedge clk);
    req_vld[p] = 1'b0;
    r_data = rsp_data;
    r_ok = rsp_sc_ok;
    chk("R3 rsp_vld", 32'(rsp_vld), 32'(1 << p));
  endtask

  task automatic ext_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    ext_wr_en = 1'b1; ext_wr_addr = a; ext_wr_data = d;
    @(negedge clk);
    ext_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_vld", 32'(rsp_vld), 0);
    do_op(0, LD, 10'h040, 0);
    chk("R1 mem zero", r_data, 0);
    do_op(0, SC, 10'h040, 32'h11);
    chk("R1 no resv", 32'(r_ok), 0);
    chk("R6 no bus_wr", 32'(r_wr), 0);
  endtask

  task automatic t_ll_sc;
    do_op(0, ST, 10'h100, 32'h5);
    chk("R3 store bus_wr", 32'(r_wr), 1);
    do_op(1, LL, 10'h100, 0);
    chk("R4 ll data", r_data, 32'h5);
    chk("R4 ll bus_rd", 32'(r_rd), 1);
    chk("R4 ll no bus_wr", 32'(r_wr), 0);
    do_op(1, SC, 10'h100, 32'h6);
    chk("R5 sc ok", 32'(r_ok), 1);
    chk("R5 sc bus_wr", 32'(r_wr), 1);
    do_op(1, SC, 10'h100, 32'h7);
    chk("R9 own sc clears", 32'(r_ok), 0);
    chk("R6 failed no bus_wr", 32'(r_wr), 0);
    do_op(2, LD, 10'h100, 0);
    chk("R6 mem unchanged", r_data, 32'h6);
  endtask

  task automatic t_steal;
    do_op(0, LL, 10'h200, 0);
    do_op(1, LL, 10'h204, 0);
    do_op(1, SC, 10'h204, 32'h7);
    chk("R7 first sc ok", 32'(r_ok), 1);
    do_op(0, SC, 10'h200, 32'h8);
    chk("R7 other sc cancels", 32'(r_ok), 0);
    do_op(3, LD, 10'h200, 0);
    chk("R6 word kept", r_data, 0);
    do_op(2, LL, 10'h300, 0);
    do_op(2, ST, 10'h304, 32'h1);
    do_op(2, SC, 10'h300, 32'h2);
    chk("R7 own store keeps", 32'(r_ok), 1);
    do_op(3, LL, 10'h310, 0);
    do_op(0, ST, 10'h318, 32'h3);
    do_op(3, SC, 10'h310, 32'h4);
    chk("R7 other store cancels", 32'(r_ok), 0);
  endtask

  task automatic t_ext;
    do_op(3, LL, 10'h080, 0);
    ext_write(10'h08C, 32'h9);
    do_op(3, SC, 10'h080, 32'hA);
    chk("R8 ext cancels", 32'(r_ok), 0);
    do_op(3, LL, 10'h080, 0);
    ext_write(10'h090, 32'h9);
    do_op(3, SC, 10'h080, 32'hB);
    chk("R10 other block keeps", 32'(r_ok), 1);
    do_op(1, LD, 10'h090, 0);
    chk("R8 ext data written", r_data, 32'h9);
  endtask

  task automatic t_replace;
    do_op(0, LL, 10'h040, 0);
    do_op(0, LL, 10'h0C0, 0);
    do_op(0, SC, 10'h040, 32'h1);
    chk("R9 old resv replaced", 32'(r_ok), 0);
    do_op(0, LL, 10'h040, 0);
    do_op(0, LL, 10'h0C0, 0);
    do_op(0, SC, 10'h0C0, 32'h2);
    chk("R9 new resv holds", 32'(r_ok), 1);
  endtask

  task automatic t_arb;
    @(negedge clk);
    set_req(2, LD, 10'h100, 0);
    set_req(1, LD, 10'h0C0, 0);
    #1;
    chk("R2 lowest wins", 32'(gnt), 32'b0010);
    chk("R2 bus addr", 32'(bus_addr), 32'h0C0);
    @(negedge clk);
    chk("R3 rsp port1", 32'(rsp_vld), 32'b0010);
    chk("R3 rsp data", rsp_data, 32'h2);
    req_vld[1] = 1'b0;
    #1;
    chk("R2 loser next", 32'(gnt), 32'b0100);
    @(negedge clk);
    chk("R3 rsp port2", 32'(rsp_vld), 32'b0100);
    chk("R3 rsp data2", rsp_data, 32'h6);
    req_vld[2] = 1'b0;
    @(negedge clk);
    ext_wr_en = 1'b1; ext_wr_addr = 10'h3F0; ext_wr_data = 32'h1;
    set_req(0, LD, 10'h3F0, 0);
    #1;
    chk("R2 ext blocks", 32'(gnt), 0);
    @(negedge clk);
    ext_wr_en = 1'b0;
    #1;
    chk("R2 granted after ext", 32'(gnt), 32'b0001);
    @(negedge clk);
    req_vld[0] = 1'b0;
    chk("R3 sees ext data", rsp_data, 32'h1);
    do_op(0, LL, 10'h1A0, 0);
    do_op(1, LL, 10'h1A0, 0);
    @(negedge clk);
    set_req(0, SC, 10'h1A0, 32'hC);
    set_req(1, SC, 10'h1A0, 32'hD);
    @(negedge clk);
    chk("R5 race winner", 32'(rsp_sc_ok), 1);
    req_vld[0] = 1'b0;
    @(negedge clk);
    chk("R7 race loser", 32'(rsp_sc_ok), 0);
    chk("R2 loser answered", 32'(rsp_vld), 32'b0010);
    req_vld[1] = 1'b0;
    do_op(2, LD, 10'h1A0, 0);
    chk("R6 race value", r_data, 32'hC);
  endtask

  initial begin
    #(200000 * 4);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ll_sc;
    t_steal;
    t_ext;
    t_replace;
    t_arb;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule